// File: doc/BRIEF.md
# RV32 Instruction Predecoder to Packed Word

This block takes one 32-bit RV32 instruction word (base integer, multiply/divide, atomics, CSR access, fence, privileged system calls and two custom system opcodes). It produces a single 54-bit word that carries everything an execution loop needs: a signed operation number, the three register indices and a fully formed 32-bit immediate. An instruction cache can store this word in place of the raw instruction, so the execute stage does no field extraction or immediate assembly.

Decoding is combinational. A single register stage holds the result. A word that arrives with the input strobe appears on the output with its own strobe one clock later. While the input strobe is low, the output word holds its last value.

Top module: `rv_predecode_pack`

## Requirements
- R1: The output word is laid out as follows:
  - bits [53:47]: the operation number, a 7-bit two's-complement value equal to (table index − 64).
  - bits [46:42]: rs2.
  - bits [41:37]: rs1.
  - bits [36:32]: rd.
  - bits [31:0]: the immediate.
- R2: `out_valid` equals the previous cycle's `in_valid`. `out_word` loads only when `in_valid` is high and holds otherwise. Reset clears both to zero.
- R3: The table indices are:
  - Branches and jumps: BEQ 0, BNE 1, JAL 2, JALR 3, BLT 4, BGE 5, BLTU 6, BGEU 7.
  - Loads and LUI: LB 8, LH 9, LW 10, LUI 11, LBU 12, LHU 13.
  - Stores: SB 14, SH 15, SW 16.
  - Atomics: AMOADD 17, AMOSWAP 18, LR 19, SC 20, AMOXOR 21, AMOOR 22, AMOAND 23, AMOMIN 24, AMOMAX 25, AMOMINU 26, AMOMAXU 27.
  - ALU: ADDI 28, SUB 29, SLTI 30, SLTIU 31, XORI 32, SRA 33, ORI 34, ANDI 35, ADD 36, SLL 37, SLT 38, SLTU 39, XOR 40, SRL 41, OR 42, AND 43.
  - Multiply/divide: MUL through REMU are 44 to 51.
  - System and others: privileged system 52, CSRRW 53, CSRRS 54, CSRRC 55, AUIPC 56, CSRRWI 57, CSRRSI 58, CSRRCI 59, FENCE 60, SLLI 61, SRLI 62, SRAI 63, illegal 64, custom-A 65, custom-B 66.
- R4: The immediate is sign-extended according to the instruction format:
  - I-format for loads, JALR and ALU-immediate operations.
  - S-format for stores.
  - B-format for branches.
  - J-format for JAL.
  - U-format (upper 20 bits, low 12 zero) for LUI and AUIPC.
  - For SLLI, SRLI and SRAI the immediate is the 5-bit shift amount, zero-extended.
- R5: Register fields that the format does not use are zero: rd for stores and branches, rs2 for I/U/J formats. Register-register and atomic operations carry a zero immediate.
- R6: CSR forms (opcode 0x73 with funct3 1, 2, 3, 5, 6, 7) carry rd, carry bits [19:15] in the rs1 field (a register or the 5-bit uimm), and carry the CSR address zero-extended in the immediate. funct3 4 is illegal.
- R7: Opcode 0x73 with funct3 0 gives index 52 with zero register fields, and its immediate is bits [31:20] zero-extended (0 ECALL, 1 EBREAK, 0x302 MRET, 0x105 WFI). It is illegal unless the rd and rs1 fields are zero.
- R8: Opcode 0x0F with funct3 0 gives FENCE (index 60) with zero registers and bits [31:20] zero-extended as the immediate. Any other funct3 is illegal.
- R9: Atomics (opcode 0x2F) require funct3 2. They are chosen by bits [31:27]: 0 ADD, 1 SWAP, 2 LR, 3 SC, 4 XOR, 8 OR, 12 AND, 16 MIN, 20 MAX, 24 MINU, 28 MAXU. Bits [26:25] are ignored. LR requires a zero rs2 field.
- R10: Opcode 0x0B gives custom-A and opcode 0x2B gives custom-B. Both use I-format fields and require funct3 0.
- R11: Anything else gives the illegal index 64 (operation number 0) with every other field zero. This covers an unknown opcode, funct3 or funct7, and any word whose bits [1:0] are not 11.
- R12: Opcode 0x33 with funct7 1 gives index 44 + funct3. With funct7 0x20 only funct3 0 (SUB) and 5 (SRA) are legal. With funct7 0 the index is 36 + funct3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word present |
| in_instr | input | 32 | Raw instruction word |
| out_valid | output | 1 | Packed word produced from the previous cycle's input |
| out_word | output | 54 | Packed decode result |

## Verification
Every field of the packed word is due exactly one clock after the edge that samples `in_valid`, and the strobe follows the same single-cycle delay. The bench drives inputs on the falling edge and lets one rising edge pass. At the next falling edge it advances a behavioural model with the inputs just latched and compares both outputs on every cycle. This includes idle cycles, where it confirms the word has held. Directed words cover every table entry, immediate-format signs and illegal field combinations. Random words, biased toward legal opcodes, fill the gaps.

// File: rtl/rv_predecode_pack.sv
module rv_predecode_pack (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_instr,
  output logic        out_valid,
  output logic [53:0] out_word
);
  localparam logic [6:0] OPC_LUI    = 7'h37;
  localparam logic [6:0] OPC_AUIPC  = 7'h17;
  localparam logic [6:0] OPC_JAL    = 7'h6F;
  localparam logic [6:0] OPC_JALR   = 7'h67;
  localparam logic [6:0] OPC_BRANCH = 7'h63;
  localparam logic [6:0] OPC_LOAD   = 7'h03;
  localparam logic [6:0] OPC_STORE  = 7'h23;
  localparam logic [6:0] OPC_OPIMM  = 7'h13;
  localparam logic [6:0] OPC_OP     = 7'h33;
  localparam logic [6:0] OPC_AMO    = 7'h2F;
  localparam logic [6:0] OPC_SYSTEM = 7'h73;
  localparam logic [6:0] OPC_FENCE  = 7'h0F;
  localparam logic [6:0] OPC_CUSTA  = 7'h0B;
  localparam logic [6:0] OPC_CUSTB  = 7'h2B;

  localparam logic [6:0] IX_JAL     = 7'd2;
  localparam logic [6:0] IX_JALR    = 7'd3;
  localparam logic [6:0] IX_LOAD0   = 7'd8;
  localparam logic [6:0] IX_LUI     = 7'd11;
  localparam logic [6:0] IX_STORE0  = 7'd14;
  localparam logic [6:0] IX_AMO0    = 7'd17;
  localparam logic [6:0] IX_OPIMM0  = 7'd28;
  localparam logic [6:0] IX_SUB     = 7'd29;
  localparam logic [6:0] IX_SRA     = 7'd33;
  localparam logic [6:0] IX_OP0     = 7'd36;
  localparam logic [6:0] IX_MUL0    = 7'd44;
  localparam logic [6:0] IX_PRIV    = 7'd52;
  localparam logic [6:0] IX_AUIPC   = 7'd56;
  localparam logic [6:0] IX_FENCE   = 7'd60;
  localparam logic [6:0] IX_SLLI    = 7'd61;
  localparam logic [6:0] IX_SRLI    = 7'd62;
  localparam logic [6:0] IX_SRAI    = 7'd63;
  localparam logic [6:0] IX_ILLEGAL = 7'd64;
  localparam logic [6:0] IX_CUSTA   = 7'd65;
  localparam logic [6:0] IX_CUSTB   = 7'd66;

  logic [6:0] opc, f7, f3x;
  logic [2:0] f3;
  logic [4:0] f5, a_rd, a_rs1, a_rs2;
  logic [31:0] imm_i, imm_s, imm_b, imm_u, imm_j, imm_z, imm_sh;

  assign opc   = in_instr[6:0];
  assign f3    = in_instr[14:12];
  assign f3x   = {4'd0, f3};
  assign f7    = in_instr[31:25];
  assign f5    = in_instr[31:27];
  assign a_rd  = in_instr[11:7];
  assign a_rs1 = in_instr[19:15];
  assign a_rs2 = in_instr[24:20];

  assign imm_i  = {{20{in_instr[31]}}, in_instr[31:20]};
  assign imm_s  = {{20{in_instr[31]}}, in_instr[31:25], in_instr[11:7]};
  assign imm_b  = {{19{in_instr[31]}}, in_instr[31], in_instr[7], in_instr[30:25], in_instr[11:8], 1'b0};
  assign imm_u  = {in_instr[31:12], 12'd0};
  assign imm_j  = {{11{in_instr[31]}}, in_instr[31], in_instr[19:12], in_instr[20], in_instr[30:21], 1'b0};
  assign imm_z  = {20'd0, in_instr[31:20]};
  assign imm_sh = {27'd0, a_rs2};

  logic        ok;
  logic [6:0]  idx;
  logic [4:0]  d_rd, d_rs1, d_rs2;
  logic [31:0] d_imm;
  logic [3:0]  amo_sel;
  logic        amo_ok;

  always_comb begin
    amo_ok  = 1'b1;
    amo_sel = 4'd0;
    case (f5)
      5'd0:    amo_sel = 4'd0;
      5'd1:    amo_sel = 4'd1;
      5'd2:    amo_sel = 4'd2;
      5'd3:    amo_sel = 4'd3;
      5'd4:    amo_sel = 4'd4;
      5'd8:    amo_sel = 4'd5;
      5'd12:   amo_sel = 4'd6;
      5'd16:   amo_sel = 4'd7;
      5'd20:   amo_sel = 4'd8;
      5'd24:   amo_sel = 4'd9;
      5'd28:   amo_sel = 4'd10;
      default: amo_ok  = 1'b0;
    endcase
  end

  always_comb begin
    ok    = 1'b0;
    idx   = IX_ILLEGAL;
    d_rd  = '0;
    d_rs1 = '0;
    d_rs2 = '0;
    d_imm = '0;
    case (opc)
      OPC_LUI: begin
        ok = 1'b1; idx = IX_LUI; d_rd = a_rd; d_imm = imm_u;
      end
      OPC_AUIPC: begin
        ok = 1'b1; idx = IX_AUIPC; d_rd = a_rd; d_imm = imm_u;
      end
      OPC_JAL: begin
        ok = 1'b1; idx = IX_JAL; d_rd = a_rd; d_imm = imm_j;
      end
      OPC_JALR: begin
        ok = (f3 == 3'd0); idx = IX_JALR; d_rd = a_rd; d_rs1 = a_rs1; d_imm = imm_i;
      end
      OPC_BRANCH: begin
        ok = (f3[2:1] != 2'b01); idx = f3x; d_rs1 = a_rs1; d_rs2 = a_rs2; d_imm = imm_b;
      end
      OPC_LOAD: begin
        ok = (f3 != 3'd3) && (f3 < 3'd6); idx = IX_LOAD0 + f3x;
        d_rd = a_rd; d_rs1 = a_rs1; d_imm = imm_i;
      end
      OPC_STORE: begin
        ok = (f3 < 3'd3); idx = IX_STORE0 + f3x;
        d_rs1 = a_rs1; d_rs2 = a_rs2; d_imm = imm_s;
      end
      OPC_OPIMM: begin
        d_rd = a_rd; d_rs1 = a_rs1;
        case (f3)
          3'd1: begin
            ok = (f7 == 7'h00); idx = IX_SLLI; d_imm = imm_sh;
          end
          3'd5: begin
            ok = (f7 == 7'h00) || (f7 == 7'h20); idx = f7[5] ? IX_SRAI : IX_SRLI; d_imm = imm_sh;
          end
          default: begin
            ok = 1'b1; idx = IX_OPIMM0 + f3x; d_imm = imm_i;
          end
        endcase
      end
      OPC_OP: begin
        d_rd = a_rd; d_rs1 = a_rs1; d_rs2 = a_rs2;
        case (f7)
          7'h00: begin ok = 1'b1; idx = IX_OP0 + f3x; end
          7'h01: begin ok = 1'b1; idx = IX_MUL0 + f3x; end
          7'h20: begin
            ok = (f3 == 3'd0) || (f3 == 3'd5); idx = (f3 == 3'd0) ? IX_SUB : IX_SRA;
          end
          default: ok = 1'b0;
        endcase
      end
      OPC_AMO: begin
        ok = (f3 == 3'd2) && amo_ok && !((f5 == 5'd2) && (a_rs2 != 5'd0));
        idx = IX_AMO0 + {3'd0, amo_sel};
        d_rd = a_rd; d_rs1 = a_rs1; d_rs2 = a_rs2;
      end
      OPC_SYSTEM: begin
        d_imm = imm_z;
        if (f3 == 3'd0) begin
          ok = (a_rd == 5'd0) && (a_rs1 == 5'd0); idx = IX_PRIV;
        end else begin
          ok = (f3 != 3'd4); idx = IX_PRIV + f3x; d_rd = a_rd; d_rs1 = a_rs1;
        end
      end
      OPC_FENCE: begin
        ok = (f3 == 3'd0); idx = IX_FENCE; d_imm = imm_z;
      end
      OPC_CUSTA, OPC_CUSTB: begin
        ok = (f3 == 3'd0); idx = (opc == OPC_CUSTA) ? IX_CUSTA : IX_CUSTB;
        d_rd = a_rd; d_rs1 = a_rs1; d_imm = imm_i;
      end
      default: ok = 1'b0;
    endcase
    if (!ok) begin
      idx   = IX_ILLEGAL;
      d_rd  = '0;
      d_rs1 = '0;
      d_rs2 = '0;
      d_imm = '0;
    end
  end

  logic [53:0] packed_word;
  assign packed_word = {idx - 7'd64, d_rs2, d_rs1, d_rd, d_imm};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_word <= packed_word;
    end
  end
endmodule

// File: rtl/rv_predecode_pack_chk.sv
module rv_predecode_pack_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] in_instr,
  input logic        out_valid,
  input logic [53:0] out_word
);
  logic [6:0] oix;
  assign oix = out_word[53:47] + 7'd64;

  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_word)));

  assert_illegal_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_word[53:47] == 7'd0) |-> (out_word[46:0] == 47'd0));

  assert_short_word_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_instr[1:0] != 2'b11) |=> (out_word[53:47] == 7'd0));

  assert_op_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($signed(out_word[53:47]) <= 7'sd2));

  assert_priv_noregs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && oix == 7'd52) |-> (out_word[46:32] == 15'd0));

  assert_no_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (oix < 7'd2 || (oix > 7'd3 && oix < 7'd8) || (oix > 7'd13 && oix < 7'd17)))
      |-> (out_word[36:32] == 5'd0));

  assert_upper_imm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (oix == 7'd11 || oix == 7'd56)) |-> (out_word[11:0] == 12'd0 && out_word[46:42] == 5'd0));
endmodule

bind rv_predecode_pack rv_predecode_pack_chk i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
  .out_valid(out_valid), .out_word(out_word)
);

// File: tb/test_rv_predecode_pack.sv
`timescale 1ns/1ps
module test_rv_predecode_pack;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] in_instr = '0;
  logic out_valid;
  logic [53:0] out_word;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic exp_v = 1'b0;
  logic [53:0] exp_w = '0;

  always #2.5 clk = ~clk;

  rv_predecode_pack i_rv_predecode_pack (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
    .out_valid(out_valid), .out_word(out_word)
  );

  function automatic logic [31:0] e_r(int f7, int rs2, int rs1, int f3, int rd, int op);
    return {f7[6:0], rs2[4:0], rs1[4:0], f3[2:0], rd[4:0], op[6:0]};
  endfunction
  function automatic logic [31:0] e_i(int imm, int rs1, int f3, int rd, int op);
    return {imm[11:0], rs1[4:0], f3[2:0], rd[4:0], op[6:0]};
  endfunction
  function automatic logic [31:0] e_s(int imm, int rs2, int rs1, int f3, int op);
    return {imm[11:5], rs2[4:0], rs1[4:0], f3[2:0], imm[4:0], op[6:0]};
  endfunction
  function automatic logic [31:0] e_b(int imm, int rs2, int rs1, int f3);
    return {imm[12], imm[10:5], rs2[4:0], rs1[4:0], f3[2:0], imm[4:1], imm[11], 7'h63};
  endfunction
  function automatic logic [31:0] e_j(int imm, int rd);
    return {imm[20], imm[10:1], imm[11], imm[19:12], rd[4:0], 7'h6F};
  endfunction

  function automatic logic [53:0] model(input logic [31:0] w);
    int opc, f3, f7, f5, id, d, s1, s2, im, ii, is, ib, ij, zz;
    int br[8]  = '{0, 1, -1, -1, 4, 5, 6, 7};
    int ld[8]  = '{8, 9, 10, -1, 12, 13, -1, -1};
    int oi[8]  = '{28, -1, 30, 31, 32, -1, 34, 35};
    int csr[8] = '{-1, 53, 54, 55, -1, 57, 58, 59};
    logic [6:0] o;
    opc = int'(w[6:0]); f3 = int'(w[14:12]); f7 = int'(w[31:25]); f5 = int'(w[31:27]);
    id = 64; d = 0; s1 = 0; s2 = 0; im = 0;
    zz = int'(w[31:20]);
    ii = w[31] ? zz - 4096 : zz;
    is = int'({w[31:25], w[11:7]}) - (w[31] ? 4096 : 0);
    ib = int'({w[7], w[30:25], w[11:8], 1'b0}) - (w[31] ? 4096 : 0);
    ij = int'({w[19:12], w[20], w[30:21], 1'b0}) - (w[31] ? 1048576 : 0);
    if (opc == 'h37 || opc == 'h17) begin
      id = (opc == 'h37) ? 11 : 56; d = int'(w[11:7]); im = int'({w[31:12], 12'd0});
    end else if (opc == 'h6F) begin
      id = 2; d = int'(w[11:7]); im = ij;
    end else if (opc == 'h67 && f3 == 0) begin
      id = 3; d = int'(w[11:7]); s1 = int'(w[19:15]); im = ii;
    end else if (opc == 'h63 && br[f3] >= 0) begin
      id = br[f3]; s1 = int'(w[19:15]); s2 = int'(w[24:20]); im = ib;
    end else if (opc == 'h03 && ld[f3] >= 0) begin
      id = ld[f3]; d = int'(w[11:7]); s1 = int'(w[19:15]); im = ii;
    end else if (opc == 'h23 && f3 <= 2) begin
      id = 14 + f3; s1 = int'(w[19:15]); s2 = int'(w[24:20]); im = is;
    end else if (opc == 'h13) begin
      d = int'(w[11:7]); s1 = int'(w[19:15]);
      if (oi[f3] >= 0) begin id = oi[f3]; im = ii; end
      else if (f3 == 1 && f7 == 0) begin id = 61; im = int'(w[24:20]); end
      else if (f3 == 5 && f7 == 0) begin id = 62; im = int'(w[24:20]); end
      else if (f3 == 5 && f7 == 32) begin id = 63; im = int'(w[24:20]); end
    end else if (opc == 'h33) begin
      d = int'(w[11:7]); s1 = int'(w[19:15]); s2 = int'(w[24:20]);
      if (f7 == 0) id = 36 + f3;
      else if (f7 == 1) id = 44 + f3;
      else if (f7 == 32 && f3 == 0) id = 29;
      else if (f7 == 32 && f3 == 5) id = 33;
    end else if (opc == 'h2F && f3 == 2) begin
      d = int'(w[11:7]); s1 = int'(w[19:15]); s2 = int'(w[24:20]);
      case (f5)
        0: id = 17; 1: id = 18; 3: id = 20; 4: id = 21; 8: id = 22; 12: id = 23;
        16: id = 24; 20: id = 25; 24: id = 26; 28: id = 27;
        2: id = (s2 == 0) ? 19 : 64;
        default: id = 64;
      endcase
    end else if (opc == 'h73) begin
      if (f3 == 0 && w[11:7] == 0 && w[19:15] == 0) begin id = 52; im = zz; end
      else if (csr[f3] >= 0) begin id = csr[f3]; d = int'(w[11:7]); s1 = int'(w[19:15]); im = zz; end
    end else if (opc == 'h0F && f3 == 0) begin
      id = 60; im = zz;
    end else if ((opc == 'h0B || opc == 'h2B) && f3 == 0) begin
      id = (opc == 'h0B) ? 65 : 66; d = int'(w[11:7]); s1 = int'(w[19:15]); im = ii;
    end
    if (id == 64) begin d = 0; s1 = 0; s2 = 0; im = 0; end
    o = 7'(id - 64);
    return {o, s2[4:0], s1[4:0], d[4:0], im[31:0]};
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (out_valid !== exp_v || out_word !== exp_w) begin
      failures++;
      $display("FAIL %s: actual valid=%0b word=%h expected valid=%0b word=%h",
               tag, out_valid, out_word, exp_v, exp_w);
    end
  endtask

  task automatic go(input bit v, input logic [31:0] w, input string tag);
    in_valid = v;
    in_instr = w;
    @(posedge clk);
    @(negedge clk);
    exp_v = v;
    if (v) exp_w = model(w);
    compare(tag);
  endtask

  task automatic go_const(input logic [31:0] w, input logic [53:0] want, input string tag);
    go(1'b1, w, tag);
    checks++;
    if (out_word !== want) begin
      failures++;
      $display("FAIL %s: actual word=%h expected %h", tag, out_word, want);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int ops[14] = '{'h37, 'h17, 'h6F, 'h67, 'h63, 'h03, 'h23, 'h13, 'h33, 'h2F, 'h73, 'h0F, 'h0B, 'h2B};
    logic [31:0] w;
    in_valid = 1'b1;
    in_instr = 32'h00000013;
    repeat (3) @(negedge clk);
    compare("R2 reset");
    rst_n = 1'b1;
    in_valid = 1'b0;

    // R1: ADDI x1,x2,-1 -> index 28, op -36
    go_const(32'hFFF10093, {7'h5C, 5'd0, 5'd2, 5'd1, 32'hFFFFFFFF}, "R1");
    // R1: SW x7,-4(x3) -> index 16, op -48
    go_const(e_s(-4, 7, 3, 2, 'h23), {7'h50, 5'd7, 5'd3, 5'd0, 32'hFFFFFFFC}, "R1");
    go_const(32'h00000000, 54'd0, "R11");

    go(1, e_i(0, 0, 0, 0, 'h37) | 32'hABCDE000, "R4");
    go(1, 32'h80000017 | 32'h00000F00, "R4");
    go(1, e_j(-2048, 1), "R4");
    go(1, e_j(1046, 31), "R4");
    go(1, e_i(-20, 5, 0, 1, 'h67), "R4");
    go(1, e_i(4, 5, 1, 1, 'h67), "R11");
    for (int f = 0; f < 8; f++) go(1, e_b((f % 2) ? -4096 : 4094, 9, 8, f), "R4");
    for (int f = 0; f < 8; f++) go(1, e_i(-2048 + f, 4, f, 6, 'h03), "R4");
    for (int f = 0; f < 4; f++) go(1, e_s(2047 - f, 12, 13, f, 'h23), "R5");
    for (int f = 0; f < 8; f++) go(1, e_i(1365 - 700 * f, 10, f, 11, 'h13), "R4");
    go(1, e_r(0, 31, 2, 1, 3, 'h13), "R4");
    go(1, e_r(0, 17, 2, 5, 3, 'h13), "R4");
    go(1, e_r(32, 9, 2, 5, 3, 'h13), "R4");
    go(1, e_r(32, 9, 2, 1, 3, 'h13), "R11");
    go(1, e_r(1, 9, 2, 5, 3, 'h13), "R11");
    for (int f = 0; f < 8; f++) go(1, e_r(0, 21, 22, f, 23, 'h33), "R12");
    for (int f = 0; f < 8; f++) go(1, e_r(1, 21, 22, f, 23, 'h33), "R12");
    for (int f = 0; f < 8; f++) go(1, e_r(32, 21, 22, f, 23, 'h33), "R12");
    go(1, e_r(2, 21, 22, 0, 23, 'h33), "R11");
    for (int k = 0; k < 32; k++) go(1, e_r(k * 4 + (k % 4), 14, 15, 2, 16, 'h2F), "R9");
    go(1, e_r(8, 0, 15, 2, 16, 'h2F), "R9");
    go(1, e_r(8, 3, 15, 2, 16, 'h2F), "R9");
    go(1, e_r(0, 14, 15, 3, 16, 'h2F), "R9");
    go(1, 32'h00000073, "R7");
    go(1, 32'h00100073, "R7");
    go(1, 32'h30200073, "R7");
    go(1, 32'h10500073, "R7");
    go(1, 32'h00000173, "R7");
    go(1, 32'h00008073, "R7");
    for (int f = 1; f < 8; f++) go(1, e_i('h300 + f, 31, f, 2, 'h73), "R6");
    go(1, e_i('hFFF, 17, 6, 0, 'h73), "R6");
    go(1, 32'h0FF0000F, "R8");
    go(1, 32'h8330000F, "R8");
    go(1, 32'h0000100F, "R8");
    go(1, e_i(-7, 3, 0, 4, 'h0B), "R10");
    go(1, e_i(99, 3, 0, 4, 'h2B), "R10");
    go(1, e_i(99, 3, 1, 4, 'h2B), "R10");
    go(1, 32'h00004501, "R11");
    go(1, 32'hFFFFFFFF, "R11");
    go(1, 32'h0000007F, "R11");
    go(0, 32'h00000037, "R2 hold");
    go(0, 32'hDEADBEEF, "R2 hold");

    for (int k = 0; k < 600; k++) begin
      w = $urandom;
      if (k % 5 != 4) w[6:0] = 7'(ops[k % 14]);
      go(k % 7 != 3, w, "R3");
    end

    go(0, 32'h0, "R2");
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule